// File: doc/BRIEF.md
# PC Card I/O Cycle Timing Sequencer

This block times one host-initiated I/O read or write toward a card slot. When it accepts a start request, it runs three phases in a fixed order. The first is a setup phase, in which the byte enable is already active. The second is a command phase, in which one active-low strobe is driven. The third is a recovery phase, in which all card controls are released. A one-clock done pulse follows the recovery phase.

The length of each phase is set by a register. The block holds two timer sets, each with its own setup, command and recovery values, and a per-set prescale input multiplies those values. A phase lasts (prescale × value + 1) clocks.

During the opening clocks of the cycle the block samples the card's 16-bit indication to decide whether the high byte enable is asserted. During the command phase it samples the card's wait request to decide whether to stretch the strobe. Address decoding, data steering and the host-bus handshake are handled elsewhere.

Top module: `pccard_io_seq`

## Requirements
- R1: An accepted cycle runs setup, then command, then recovery. `ce_lo_n` is low during setup and command and high during recovery and idle.
- R2: `set_sel` chooses timer set 0 or 1 when a start is accepted. The register write port selects a set with `cfg_set` and a field with `cfg_field` (0 = setup, 1 = command, 2 = recovery). A write to field 3 is dropped.
- R3: Each phase lasts exactly (prescale × programmed value + 1) clocks. The prescale is `pre0` or `pre1`, according to the selected set.
- R4: After reset, set 0 holds setup 1, command 6 and recovery 3, and set 1 holds 0 in all three fields.
- R5: A programmed value of 0 gives a phase of exactly one clock, whatever the prescale.
- R6: `card_io16_n` is sampled in the first 3 clocks of the cycle, counted from the first setup clock. If it is low in any of them, `ce_hi_n` goes low from the next clock until the command phase ends. If it is low only later, it is ignored and `ce_hi_n` stays high for that cycle.
- R7: During the command phase exactly one strobe is low. It is `wr_n` when `start_write` was 1 at acceptance and `rd_n` when it was 0. Both strobes are high outside the command phase.
- R8: The wait request is honoured if `card_wait_n` is low within the first 2 command clocks. After that, the strobe stays low in every clock in which wait is low, and for 2 further clocks after wait returns high, but never for less than the programmed length.
- R9: A wait that first goes low in or after the third command clock has no effect on the command length.
- R10: Register writes made during a cycle take effect only from the next accepted cycle.
- R11: `done` is high for exactly one clock, right after the last recovery clock. A start request is accepted only while idle; requests made during a cycle are dropped.
- R12: During and after reset, both strobes, both byte enables and `done` are inactive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Cycle request, accepted only while idle |
| start_write | input | 1 | Direction at acceptance: 1 = write, 0 = read |
| set_sel | input | 1 | Timer set used by the accepted cycle |
| pre0 | input | PRE_W | Prescale for timer set 0 |
| pre1 | input | PRE_W | Prescale for timer set 1 |
| cfg_we | input | 1 | Timing register write enable |
| cfg_set | input | 1 | Timer set addressed by a write |
| cfg_field | input | 2 | Field addressed: 0 setup, 1 command, 2 recovery |
| cfg_data | input | VAL_W | Value written |
| card_io16_n | input | 1 | Card 16-bit I/O indication, active low |
| card_wait_n | input | 1 | Card wait request, active low |
| rd_n | output | 1 | Read command strobe, active low |
| wr_n | output | 1 | Write command strobe, active low |
| ce_lo_n | output | 1 | Low byte enable, active low |
| ce_hi_n | output | 1 | High byte enable, active low |
| done | output | 1 | One-clock pulse when the cycle ends |

## Verification
The bench drives the 16-bit indication at the last clock inside its window and then at the first clock outside it. A window that is off by one would grant or refuse the high byte enable in the wrong one of the two cases.

It raises wait inside the command window, and separately one clock past it. The stretched case must end exactly two clocks after wait is released. A sequencer with the window or hold count wrong would give a command length off by one or more clocks, or would stretch on the late wait.

It rewrites a timing register in the middle of a cycle and issues a start while the block is busy. A design that read the registers live would change the running cycle. A design that accepted starts at any time would restart, which shows as a missing done pulse or as byte-enable activity after done.

// File: rtl/pccard_io_seq.sv
module pccard_io_seq #(
  parameter int VAL_W     = 8,
  parameter int PRE_W     = 9,
  parameter int IO16_WIN  = 3,
  parameter int WAIT_WIN  = 2,
  parameter int WAIT_HOLD = 2,
  parameter int RST_SET   = 1,
  parameter int RST_CMD   = 6,
  parameter int RST_REC   = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             start_write,
  input  logic             set_sel,
  input  logic [PRE_W-1:0] pre0,
  input  logic [PRE_W-1:0] pre1,
  input  logic             cfg_we,
  input  logic             cfg_set,
  input  logic [1:0]       cfg_field,
  input  logic [VAL_W-1:0] cfg_data,
  input  logic             card_io16_n,
  input  logic             card_wait_n,
  output logic             rd_n,
  output logic             wr_n,
  output logic             ce_lo_n,
  output logic             ce_hi_n,
  output logic             done
);
  localparam int CNT_W  = VAL_W + PRE_W;
  localparam int AGE_W  = $clog2(IO16_WIN + 1);
  localparam int CAGE_W = $clog2(WAIT_WIN + 1);
  localparam int HOLD_W = $clog2(WAIT_HOLD + 1);

  typedef enum logic [1:0] {S_IDLE, S_SETUP, S_CMD, S_REC} state_t;

  state_t             state;
  logic [VAL_W-1:0]   tv [2][3];
  logic [CNT_W-1:0]   cnt, cmd_q, rec_q;
  logic [AGE_W-1:0]   age;
  logic [CAGE_W-1:0]  cage;
  logic [HOLD_W-1:0]  hold;
  logic               dir, wide, stretched;

  logic [PRE_W-1:0] sel_pre;
  logic [CNT_W-1:0] prod_s, prod_c, prod_r;
  logic             waiting, active;

  assign sel_pre = set_sel ? pre1 : pre0;
  assign prod_s  = CNT_W'(sel_pre) * CNT_W'(tv[set_sel][0]);
  assign prod_c  = CNT_W'(sel_pre) * CNT_W'(tv[set_sel][1]);
  assign prod_r  = CNT_W'(sel_pre) * CNT_W'(tv[set_sel][2]);

  assign waiting = (state == S_CMD) && !card_wait_n &&
                   (stretched || cage < CAGE_W'(WAIT_WIN));
  assign active  = (state == S_SETUP) || (state == S_CMD);

  assign rd_n    = !((state == S_CMD) && !dir);
  assign wr_n    = !((state == S_CMD) && dir);
  assign ce_lo_n = !active;
  assign ce_hi_n = !(active && wide);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < 2; s++) begin
        tv[s][0] <= (s == 0) ? VAL_W'(RST_SET) : '0;
        tv[s][1] <= (s == 0) ? VAL_W'(RST_CMD) : '0;
        tv[s][2] <= (s == 0) ? VAL_W'(RST_REC) : '0;
      end
    end else if (cfg_we && cfg_field != 2'd3) begin
      tv[cfg_set][cfg_field] <= cfg_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      cnt       <= '0;
      cmd_q     <= '0;
      rec_q     <= '0;
      dir       <= 1'b0;
      age       <= '0;
      cage      <= '0;
      hold      <= '0;
      wide      <= 1'b0;
      stretched <= 1'b0;
      done      <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: if (start) begin
          state     <= S_SETUP;
          cnt       <= prod_s;
          cmd_q     <= prod_c;
          rec_q     <= prod_r;
          dir       <= start_write;
          age       <= '0;
          cage      <= '0;
          hold      <= '0;
          wide      <= 1'b0;
          stretched <= 1'b0;
        end
        S_SETUP: begin
          if (cnt == '0) begin
            state <= S_CMD;
            cnt   <= cmd_q;
          end else begin
            cnt <= cnt - CNT_W'(1);
          end
        end
        S_CMD: begin
          if (cage < CAGE_W'(WAIT_WIN)) cage <= cage + CAGE_W'(1);
          if (waiting) begin
            stretched <= 1'b1;
            hold      <= HOLD_W'(WAIT_HOLD - 1);
          end else if (hold != '0) begin
            hold <= hold - HOLD_W'(1);
          end
          if (cnt != '0) cnt <= cnt - CNT_W'(1);
          if (cnt == '0 && hold == '0 && !waiting) begin
            state <= S_REC;
            cnt   <= rec_q;
          end
        end
        default: begin
          if (cnt == '0) begin
            state <= S_IDLE;
            done  <= 1'b1;
          end else begin
            cnt <= cnt - CNT_W'(1);
          end
        end
      endcase
      if (state != S_IDLE && age < AGE_W'(IO16_WIN)) begin
        age <= age + AGE_W'(1);
        if (!card_io16_n) wide <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/pccard_io_seq_chk.sv
module pccard_io_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic rd_n,
  input logic wr_n,
  input logic ce_lo_n,
  input logic ce_hi_n,
  input logic done,
  input logic card_wait_n,
  input logic stretched
);
  assert_one_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(!rd_n && !wr_n));

  assert_strobe_inside_enable_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_n || !wr_n) |-> !ce_lo_n);

  assert_hi_inside_lo_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !ce_hi_n |-> !ce_lo_n);

  assert_done_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_when_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (ce_lo_n && rd_n && wr_n));

  assert_wait_holds_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((!rd_n || !wr_n) && stretched && !card_wait_n) |=> (!rd_n || !wr_n));
endmodule

bind pccard_io_seq pccard_io_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rd_n(rd_n), .wr_n(wr_n), .ce_lo_n(ce_lo_n),
  .ce_hi_n(ce_hi_n), .done(done), .card_wait_n(card_wait_n), .stretched(stretched)
);

// File: tb/pccard_io_seq_tb.sv
module pccard_io_seq_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0, start_write = 1'b0, set_sel = 1'b0;
  logic [8:0] pre0 = 9'd1, pre1 = 9'd16;
  logic       cfg_we = 1'b0, cfg_set = 1'b0;
  logic [1:0] cfg_field = 2'd0;
  logic [7:0] cfg_data = 8'd0;
  logic       card_io16_n = 1'b1, card_wait_n = 1'b1;
  logic       rd_n, wr_n, ce_lo_n, ce_hi_n, done;

  int checks = 0, failures = 0;
  int n_set, n_cmd, n_rec;
  bit saw_hi, bad_dir, bad_order, post_ok;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  pccard_io_seq u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .start_write(start_write),
    .set_sel(set_sel), .pre0(pre0), .pre1(pre1), .cfg_we(cfg_we),
    .cfg_set(cfg_set), .cfg_field(cfg_field), .cfg_data(cfg_data),
    .card_io16_n(card_io16_n), .card_wait_n(card_wait_n),
    .rd_n(rd_n), .wr_n(wr_n), .ce_lo_n(ce_lo_n), .ce_hi_n(ce_hi_n), .done(done)
  );

  task automatic check_eq(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic wcfg(input bit s, input logic [1:0] f, input logic [7:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_set = s; cfg_field = f; cfg_data = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // k counts clocks from the first setup clock; inputs set at negedge k are sampled at the end of clock k
  task automatic run_seq(input bit sel, input bit w, input int io16_k,
                         input int wlo, input int whi, input int blo, input int bhi,
                         input int cfg_k);
    int k;
    int ph;
    n_set = 0; n_cmd = 0; n_rec = 0;
    saw_hi = 0; bad_dir = 0; bad_order = 0; ph = 0;
    @(negedge clk);
    start = 1'b1; start_write = w; set_sel = sel;
    @(negedge clk);
    start = 1'b0;
    k = 0;
    while (k < 5000 && !done) begin
      if (!rd_n || !wr_n) begin
        n_cmd++;
        if (ph > 1) bad_order = 1;
        ph = 1;
        if (w ? !(!wr_n && rd_n) : !(!rd_n && wr_n)) bad_dir = 1;
      end else if (!ce_lo_n) begin
        n_set++;
        if (ph != 0) bad_order = 1;
      end else begin
        n_rec++;
        if (ph == 0) bad_order = 1;
        ph = 2;
      end
      if (!ce_hi_n) saw_hi = 1;
      card_io16_n = (k == io16_k) ? 1'b0 : 1'b1;
      card_wait_n = (k >= wlo && k < whi) ? 1'b0 : 1'b1;
      start = (k >= blo && k < bhi);
      cfg_we = (k == cfg_k);
      cfg_set = 1'b0; cfg_field = 2'd1; cfg_data = 8'd2;
      @(negedge clk);
      k++;
    end
    card_io16_n = 1'b1; card_wait_n = 1'b1; start = 1'b0; cfg_we = 1'b0;
    @(negedge clk);
    post_ok = !done && ce_lo_n && rd_n && wr_n;
  endtask

  task automatic expect_phases(string req, int s, int c, int r);
    check_eq(req, "setup clocks", n_set, s);
    check_eq(req, "command clocks", n_cmd, c);
    check_eq(req, "recovery clocks", n_rec, r);
    check_eq("R1", "phase order intact", int'(bad_order), 0);
    check_eq("R11", "done single and idle after", int'(post_ok), 1);
  endtask

  task automatic t_reset();
    check_eq("R12", "rd_n after reset", int'(rd_n), 1);
    check_eq("R12", "wr_n after reset", int'(wr_n), 1);
    check_eq("R12", "ce_lo_n after reset", int'(ce_lo_n), 1);
    check_eq("R12", "ce_hi_n after reset", int'(ce_hi_n), 1);
    check_eq("R12", "done after reset", int'(done), 0);
  endtask

  task automatic t_default_read();
    run_seq(0, 0, -1, -1, -1, -1, -1, -1);
    expect_phases("R4", 2, 7, 4);
    check_eq("R7", "read strobe only", int'(bad_dir), 0);
    check_eq("R6", "no high enable without io16", int'(saw_hi), 0);
  endtask

  task automatic t_io16_edge();
    run_seq(0, 1, 2, -1, -1, -1, -1, -1);
    check_eq("R6", "io16 in last window clock honoured", int'(saw_hi), 1);
    check_eq("R7", "write strobe only", int'(bad_dir), 0);
    run_seq(0, 1, 3, -1, -1, -1, -1, -1);
    check_eq("R6", "io16 after window ignored", int'(saw_hi), 0);
    expect_phases("R3", 2, 7, 4);
  endtask

  task automatic t_set1();
    run_seq(1, 0, -1, -1, -1, -1, -1, -1);
    expect_phases("R5", 1, 1, 1);
    wcfg(1, 2'd0, 8'd0);
    wcfg(1, 2'd1, 8'd1);
    wcfg(1, 2'd2, 8'd2);
    wcfg(1, 2'd3, 8'd9);
    run_seq(1, 1, -1, -1, -1, -1, -1, -1);
    expect_phases("R2", 1, 17, 33);
    run_seq(0, 0, -1, -1, -1, -1, -1, -1);
    expect_phases("R2", 2, 7, 4);
  endtask

  task automatic t_wait();
    run_seq(0, 0, -1, 3, 12, -1, -1, -1);
    expect_phases("R8", 2, 12, 4);
    run_seq(0, 0, -1, 2, 3, -1, -1, -1);
    expect_phases("R8", 2, 7, 4);
    run_seq(0, 0, -1, 4, 12, -1, -1, -1);
    expect_phases("R9", 2, 7, 4);
  endtask

  task automatic t_latch();
    run_seq(0, 0, -1, -1, -1, -1, -1, 1);
    expect_phases("R10", 2, 7, 4);
    run_seq(0, 0, -1, -1, -1, -1, -1, -1);
    expect_phases("R10", 2, 3, 4);
    wcfg(0, 2'd1, 8'd6);
  endtask

  task automatic t_busy_start();
    run_seq(0, 1, -1, -1, -1, 3, 6, -1);
    expect_phases("R11", 2, 7, 4);
    repeat (3) @(negedge clk);
    check_eq("R11", "no restart from busy request", int'(ce_lo_n), 1);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_default_read();
    t_io16_edge();
    t_set1();
    t_wait();
    t_latch();
    t_busy_start();
    finish_run();
  end

  initial begin
    #(200000 * 10);
    failures++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end
endmodule